// File: doc/BRIEF.md
# Folded Lookup ROM with Column Group Select

This block is a read-only lookup table with a logical view of 2^ADDR_W words of DATA_W bits each. Each address selects exactly one word, so every output bit is an arbitrary function of the address. Any set of DATA_W functions of ADDR_W inputs can therefore be stored as a multiple-output truth table.

The words are not kept as a flat word array. They are folded into a physical bit array of 2^ROW_W rows. Each row holds 2^(ADDR_W-ROW_W) column groups of DATA_W bits. The upper address bits drive a one-hot row decoder. A row is then formed as an OR over the decoded lines. A column group multiplexer picks the addressed group and registers it.

Before use, the contents are loaded one word per cycle through a program port. After loading, the read port returns the stored word one cycle after each accepted read. The default shape is 8192 words of 8 bits held as 128 rows of 512 bits. An 8-word by 4-bit shape is obtained from the parameters alone.

Top module: `rom2d_fold`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, rd_valid_o is 0 and rd_data_o is all zeros.
- R2: Address bits [ADDR_W-1:ADDR_W-ROW_W] pick the row. The low ADDR_W-ROW_W bits pick column group k, which spans physical columns k*DATA_W to k*DATA_W+DATA_W-1. Words that share a row are stored and read back independently of one another.
- R3: A cycle with prog_en_i high stores prog_data_i at prog_addr_i. A read accepted in the next cycle returns that value.
- R4: After reset, any location that has not been programmed reads as all zeros.
- R5: A read is accepted in a cycle where rd_en_i is high and prog_en_i is low. In the following cycle, rd_valid_o is 1 and rd_data_o holds the word at rd_addr_i.
- R6: In a cycle where prog_en_i is high, a read request is ignored. In the next cycle rd_valid_o is 0 and rd_data_o keeps its previous value.
- R7: Without an accepted read, rd_data_o keeps its value and rd_valid_o is 0.
- R8: Programming an address that already holds a word replaces that word with the new data.
- R9: With ADDR_W=3, DATA_W=4 and ROW_W=2 (an 8x4 table in 4 rows of 8 bits), R3 and R5 hold for all 8 addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the array |
| prog_en_i | input | 1 | Program strobe; stores one word per cycle |
| prog_addr_i | input | ADDR_W | Logical word address to program |
| prog_data_i | input | DATA_W | Word to store |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Logical word address to read |
| rd_data_o | output | DATA_W | Registered read word |
| rd_valid_o | output | 1 | High in the cycle after an accepted read |

## Verification
The assertions check several rules on every cycle:
- the row decoder presents exactly one row to the array;
- a read request during programming never produces a valid result, and the output stays steady without an accepted read;
- an accepted read is always followed by a valid result;
- a write followed at once by a read of the same address returns the written word.

Some behaviour only the bench scenarios can show. These are the all-zero contents after reset and the independence of neighbouring groups in one row. They also include overwrite, correct lookup of a loaded square-root table at every address, and correct operation of the small 8x4 shape.

// File: rtl/rom2d_pkg.sv
package rom2d_pkg;

  // Lowest physical column of a column group inside a row
  function automatic int unsigned grp_lsb(input int unsigned grp, input int unsigned data_w);
    return grp * data_w;
  endfunction

endpackage

// File: rtl/rom2d_row_dec.sv
module rom2d_row_dec #(
  parameter int unsigned ROW_W = 7,
  localparam int unsigned ROWS = 1 << ROW_W
) (
  input  logic [ROW_W-1:0] row_addr_i,
  output logic [ROWS-1:0]  row_sel_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_line
    assign row_sel_o[r] = (row_addr_i == ROW_W'(r));
  end

endmodule

// File: rtl/rom2d_array.sv
module rom2d_array
  import rom2d_pkg::*;
#(
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned COL_W  = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ROWS     = 1 << ROW_W,
  localparam int unsigned GROUPS   = 1 << COL_W,
  localparam int unsigned ROW_BITS = GROUPS * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ROW_W-1:0]    wr_row_i,
  input  logic [COL_W-1:0]    wr_grp_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ROWS-1:0]     row_sel_i,
  output logic [ROW_BITS-1:0] row_data_o
);

  logic [ROW_BITS-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_row_i][grp_lsb(int'(wr_grp_i), DATA_W) +: DATA_W] <= wr_data_i;
    end
  end

  // Wired-OR plane: selected row lines drive the column bus
  always_comb begin
    row_data_o = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_sel_i[r]) row_data_o = row_data_o | mem_q[r];
    end
  end

  AST_ROW_SEL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(row_sel_i)); // R2

endmodule

// File: rtl/rom2d_col_mux.sv
module rom2d_col_mux #(
  parameter int unsigned COL_W  = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned GROUPS   = 1 << COL_W,
  localparam int unsigned ROW_BITS = GROUPS * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_i,
  input  logic [COL_W-1:0]    grp_i,
  input  logic [ROW_BITS-1:0] row_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                valid_o
);

  logic [DATA_W-1:0] grp_w [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_w[g] = row_i[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) data_o <= grp_w[grp_i];
    end
  end

endmodule

// File: rtl/rom2d_fold.sv
module rom2d_fold #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ROW_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);

  // ROW_W must leave at least one column address bit
  localparam int unsigned COL_W    = ADDR_W - ROW_W;
  localparam int unsigned ROWS     = 1 << ROW_W;
  localparam int unsigned ROW_BITS = (1 << COL_W) * DATA_W;

  logic [ROW_W-1:0]    rd_row;
  logic [COL_W-1:0]    rd_grp;
  logic [ROWS-1:0]     row_sel;
  logic [ROW_BITS-1:0] row_data;
  logic                rd_fire;

  assign rd_row  = rd_addr_i[ADDR_W-1:COL_W];
  assign rd_grp  = rd_addr_i[COL_W-1:0];
  assign rd_fire = rd_en_i && !prog_en_i;

  rom2d_row_dec #(.ROW_W(ROW_W)) u_row_dec (
    .row_addr_i (rd_row),
    .row_sel_o  (row_sel)
  );

  rom2d_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (prog_en_i),
    .wr_row_i   (prog_addr_i[ADDR_W-1:COL_W]),
    .wr_grp_i   (prog_addr_i[COL_W-1:0]),
    .wr_data_i  (prog_data_i),
    .row_sel_i  (row_sel),
    .row_data_o (row_data)
  );

  rom2d_col_mux #(.COL_W(COL_W), .DATA_W(DATA_W)) u_col_mux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (rd_fire),
    .grp_i   (rd_grp),
    .row_i   (row_data),
    .data_o  (rd_data_o),
    .valid_o (rd_valid_o)
  );

  AST_READ_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |=> !rd_valid_o); // R6

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !prog_en_i) |=> $stable(rd_data_o)); // R7

  AST_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !prog_en_i) |=> rd_valid_o); // R5

  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !prog_en_i && $past(prog_en_i) && rd_addr_i == $past(prog_addr_i))
      |=> rd_data_o == $past(prog_data_i, 2)); // R3

endmodule

// File: tb/rom2d_fold_bench.sv
module rom2d_fold_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13, DW = 8, RW = 7;
  localparam int SAW = 3, SDW = 4, SRW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          prog_en = 0, rd_en = 0;
  logic [AW-1:0] prog_addr = '0, rd_addr = '0;
  logic [DW-1:0] prog_data = '0, rd_data;
  logic          rd_valid;

  logic           s_prog_en = 0, s_rd_en = 0;
  logic [SAW-1:0] s_prog_addr = '0, s_rd_addr = '0;
  logic [SDW-1:0] s_prog_data = '0, s_rd_data;
  logic           s_rd_valid;

  int n_checks = 0;
  int n_fail   = 0;

  rom2d_fold #(.ADDR_W(AW), .DATA_W(DW), .ROW_W(RW)) u_rom2d_fold (
    .clk_i(clk), .rst_ni(rst_n),
    .prog_en_i(prog_en), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  rom2d_fold #(.ADDR_W(SAW), .DATA_W(SDW), .ROW_W(SRW)) u_rom2d_fold_small (
    .clk_i(clk), .rst_ni(rst_n),
    .prog_en_i(s_prog_en), .prog_addr_i(s_prog_addr), .prog_data_i(s_prog_data),
    .rd_en_i(s_rd_en), .rd_addr_i(s_rd_addr),
    .rd_data_o(s_rd_data), .rd_valid_o(s_rd_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prog(input int a, input int d);
    prog_en = 1; prog_addr = AW'(a); prog_data = DW'(d);
    @(negedge clk);
    prog_en = 0;
  endtask

  task automatic read_chk(input string req, input int a, input int exp);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    check(req, int'(rd_valid), 1);
    check(req, int'(rd_data), exp);
  endtask

  function automatic int isqrt(input int n);
    int r = 0;
    while ((r + 1) * (r + 1) <= n) r++;
    return r;
  endfunction

  task automatic t_reset();
    check("R1 valid", int'(rd_valid), 0);
    check("R1 data", int'(rd_data), 0);
    @(negedge clk);
    check("R1 valid after release", int'(rd_valid), 0);
  endtask

  task automatic t_blank();
    read_chk("R4", 0, 0);
    read_chk("R4", 8191, 0);
    read_chk("R4", 1234, 0);
  endtask

  task automatic t_sqrt_table();
    for (int i = 0; i < 16; i++) prog(i, isqrt(i));
    for (int i = 0; i < 16; i++) read_chk("R5 sqrt", i, isqrt(i));
  endtask

  task automatic t_fold();
    // row 1 group 0, row 1 group 63, last row last group
    prog(64, 8'hA5);
    prog(127, 8'h3C);
    prog(8191, 8'hFF);
    prog(8190, 8'h81);
    read_chk("R2 row1 grp0", 64, 8'hA5);
    read_chk("R2 row1 grp63", 127, 8'h3C);
    read_chk("R2 last", 8191, 8'hFF);
    read_chk("R2 last-1", 8190, 8'h81);
    read_chk("R2 row1 grp1 untouched", 65, 0);
    read_chk("R2 row0 intact", 15, isqrt(15));
  endtask

  task automatic t_write_then_read();
    prog(300, 8'h5A);
    read_chk("R3", 300, 8'h5A);
  endtask

  task automatic t_overwrite();
    prog(64, 8'h11);
    read_chk("R8", 64, 8'h11);
    read_chk("R8 neighbour", 127, 8'h3C);
  endtask

  task automatic t_blocked();
    int held;
    read_chk("R6 setup", 4, 2);
    held = int'(rd_data);
    prog_en = 1; prog_addr = AW'(500); prog_data = 8'h77;
    rd_en = 1; rd_addr = AW'(64);
    @(negedge clk);
    prog_en = 0; rd_en = 0;
    check("R6 no valid", int'(rd_valid), 0);
    check("R6 data held", int'(rd_data), held);
    read_chk("R6 write still done", 500, 8'h77);
  endtask

  task automatic t_idle();
    int held;
    held = int'(rd_data);
    rd_addr = AW'(64);
    @(negedge clk);
    @(negedge clk);
    check("R7 no valid", int'(rd_valid), 0);
    check("R7 data held", int'(rd_data), held);
  endtask

  task automatic t_small();
    for (int i = 0; i < 8; i++) begin
      s_prog_en = 1; s_prog_addr = SAW'(i); s_prog_data = SDW'(i * 5 + 3);
      @(negedge clk);
    end
    s_prog_en = 0;
    for (int i = 0; i < 8; i++) begin
      s_rd_en = 1; s_rd_addr = SAW'(i);
      @(negedge clk);
      s_rd_en = 0;
      check("R9 valid", int'(s_rd_valid), 1);
      check("R9 data", int'(s_rd_data), (i * 5 + 3) & 15);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_blank();
    t_sqrt_table();
    t_fold();
    t_write_then_read();
    t_overwrite();
    t_blocked();
    t_idle();
    t_small();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule